// File: doc/BRIEF.md
# Coprocessor Dispatch and Timeout Controller

This block sits on the host side of an external coprocessor port. When the pipeline issues an instruction the core cannot execute itself, and that instruction does not branch, the controller captures the already decoded instruction word and the two fetched operand values. It then presents them to the coprocessor with a valid flag and holds them steady until the instruction finishes.

The coprocessor has three ways to answer. It can raise ready, which completes the instruction. It can raise wait, which tells the host it needs more time. Or it can stay silent. If valid has been high for 16 cycles with neither ready nor wait, the controller gives up. It pulses an illegal-instruction exception and returns to idle. Once wait has been seen, no timeout applies, and the instruction ends only when ready arrives. On ready, the returned value is written to the destination register named by the instruction, but only if the coprocessor also requests a write. Completion is reported to the pipeline by a one-cycle done strobe.

Top module: `cop_dispatch`

## Requirements
- R1: After reset the controller is idle: iss_ready is 1, and cp_valid, done, exc_pulse and rf_we are 0.
- R2: When iss_valid is 1 while iss_ready is 1, cp_valid is 1 in the next cycle, and cp_insn, cp_opa and cp_opb equal the issued word and operands. iss_ready is 0 for as long as cp_valid is 1.
- R3: While cp_valid is 1, cp_insn, cp_opa and cp_opb do not change. An iss_valid that arrives while the controller is busy is ignored.
- R4: Suppose cp_valid has been 1 for 16 cycles and neither cp_ready nor cp_wait was 1 in any of them. Then in the following cycle exc_pulse is 1 for exactly one cycle, cp_valid is 0, and done and rf_we stay 0.
- R5: A cp_ready that arrives in the 16th cycle of cp_valid completes the instruction normally, and no exception is raised.
- R6: Once cp_wait has been 1 in any cycle of cp_valid, no exception is raised for that instruction. cp_valid stays 1 until cp_ready arrives, however long that takes.
- R7: When cp_ready and cp_wr are both 1, and the rd field (instruction bits [11:7]) is not zero, the next cycle has rf_we=1, rf_idx equal to that rd field and rf_data equal to cp_result.
- R8: When cp_ready is 1 and cp_wr is 0, the instruction completes with rf_we kept at 0.
- R9: A write whose rd field is 0 is suppressed, so rf_we stays 0.
- R10: In the cycle after cp_ready, done is 1 for one cycle and cp_valid is 0. done and exc_pulse are never 1 together.
- R11: The cycle counter restarts at every new issue. The 16-cycle timeout window is therefore never shortened by cycles counted for an earlier instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Pipeline presents an instruction to forward |
| iss_insn | input | 32 | Decoded instruction word |
| iss_opa | input | 32 | First operand value |
| iss_opb | input | 32 | Second operand value |
| iss_ready | output | 1 | Controller is idle and takes an issue |
| cp_valid | output | 1 | Instruction offered to the coprocessor |
| cp_insn | output | 32 | Instruction word to the coprocessor |
| cp_opa | output | 32 | First operand to the coprocessor |
| cp_opb | output | 32 | Second operand to the coprocessor |
| cp_ready | input | 1 | Coprocessor has finished |
| cp_wait | input | 1 | Coprocessor claims the instruction and needs more time |
| cp_wr | input | 1 | Coprocessor requests a register write with ready |
| cp_result | input | 32 | Result value from the coprocessor |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 5 | Destination register index |
| rf_data | output | 32 | Data to write |
| done | output | 1 | One-cycle completion strobe |
| exc_pulse | output | 1 | One-cycle illegal-instruction exception |

## Verification
The assertions check several properties on every cycle:
- the offered word and operands stay frozen while the controller is busy;
- an accepted issue appears on the coprocessor side one cycle later;
- the counter stays within its range and is cleared when an issue is accepted;
- no exception follows a claimed instruction;
- done and the exception are exclusive, and the exception lasts one cycle;
- a write never targets register 0.

Some behaviour only the bench scenarios can show:
- the exact cycle of the timeout against a ready arriving in the last allowed cycle;
- waits that last far beyond 16 cycles;
- the write-back index and data under random rd fields and write requests;
- the fact that a busy-time issue leaves the outputs untouched.

// File: rtl/cop_pkg.sv
package cop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POLL = 2'd1,
        ST_HOLD = 2'd2
    } cop_state_e;

    // lowest bit of the destination register field in the instruction word
    localparam int RD_LSB = 7;
endpackage

// File: rtl/cop_timeout.sv
module cop_timeout #(
    parameter int LIMIT = 16,
    parameter int CNT_W = $clog2(LIMIT) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = run && (cnt_q == LAST);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R11
    clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/cop_commit.sv
module cop_commit #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin,
    input  logic              wr_req,
    input  logic [RIDX_W-1:0] rd,
    input  logic [XLEN-1:0]   result,
    input  logic              tmo,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_idx,
    output logic [XLEN-1:0]   rf_data,
    output logic              done,
    output logic              exc_pulse
);
    typedef struct packed {
        logic              we;
        logic [RIDX_W-1:0] idx;
        logic [XLEN-1:0]   data;
        logic              done;
        logic              exc;
    } wb_t;

    wb_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        w_d.we   = fin && wr_req && (rd != '0);
        w_d.done = fin;
        w_d.exc  = tmo && !fin;
        if (fin) begin
            w_d.idx  = rd;
            w_d.data = result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign rf_we     = w_q.we;
    assign rf_idx    = w_q.idx;
    assign rf_data   = w_q.data;
    assign done      = w_q.done;
    assign exc_pulse = w_q.exc;

    // R9
    no_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.we |-> (w_q.idx != '0));

    // R10
    done_exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_q.done && w_q.exc));

    // R4
    exc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.exc |=> !w_q.exc);
endmodule

// File: rtl/cop_dispatch.sv
module cop_dispatch
    import cop_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ILEN    = 32,
    parameter int TIMEOUT = 16,
    parameter int RIDX_W  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic [ILEN-1:0] iss_insn,
    input  logic [XLEN-1:0] iss_opa,
    input  logic [XLEN-1:0] iss_opb,
    output logic            iss_ready,
    output logic            cp_valid,
    output logic [ILEN-1:0] cp_insn,
    output logic [XLEN-1:0] cp_opa,
    output logic [XLEN-1:0] cp_opb,
    input  logic            cp_ready,
    input  logic            cp_wait,
    input  logic            cp_wr,
    input  logic [XLEN-1:0] cp_result,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_idx,
    output logic [XLEN-1:0]   rf_data,
    output logic            done,
    output logic            exc_pulse
);
    localparam int CNT_W = $clog2(TIMEOUT) + 1;

    typedef struct packed {
        cop_state_e      st;
        logic [ILEN-1:0] insn;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
    } ctl_t;

    ctl_t c_d, c_q;
    logic accept, fin, tmo, poll_run, expire;
    logic [RIDX_W-1:0] rd_fld;

    assign poll_run = (c_q.st == ST_POLL) && !cp_ready && !cp_wait;
    assign rd_fld   = c_q.insn[RD_LSB +: RIDX_W];

    always_comb begin
        c_d    = c_q;
        accept = 1'b0;
        fin    = 1'b0;
        tmo    = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (iss_valid) begin
                    accept = 1'b1;
                    c_d.st   = ST_POLL;
                    c_d.insn = iss_insn;
                    c_d.opa  = iss_opa;
                    c_d.opb  = iss_opb;
                end
            end
            ST_POLL: begin
                if (cp_ready) begin
                    fin    = 1'b1;
                    c_d.st = ST_IDLE;
                end else if (cp_wait) begin
                    c_d.st = ST_HOLD;
                end else if (expire) begin
                    tmo    = 1'b1;
                    c_d.st = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (cp_ready) begin
                    fin    = 1'b1;
                    c_d.st = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign iss_ready = (c_q.st == ST_IDLE);
    assign cp_valid  = (c_q.st != ST_IDLE);
    assign cp_insn   = c_q.insn;
    assign cp_opa    = c_q.opa;
    assign cp_opb    = c_q.opb;

    cop_timeout #(
        .LIMIT (TIMEOUT),
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .run    (poll_run),
        .expire (expire)
    );

    cop_commit #(
        .XLEN   (XLEN),
        .RIDX_W (RIDX_W)
    ) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin       (fin),
        .wr_req    (cp_wr),
        .rd        (rd_fld),
        .result    (cp_result),
        .tmo       (tmo),
        .rf_we     (rf_we),
        .rf_idx    (rf_idx),
        .rf_data   (rf_data),
        .done      (done),
        .exc_pulse (exc_pulse)
    );

    // R2
    issue_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_ready && iss_valid) |=> (cp_valid && !iss_ready &&
            cp_insn == $past(iss_insn) && cp_opa == $past(iss_opa) &&
            cp_opb == $past(iss_opb)));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && !cp_ready && !tmo) |=> (cp_valid && $stable(cp_insn) &&
            $stable(cp_opa) && $stable(cp_opb)));

    // R6
    claimed_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_HOLD) |=> !exc_pulse);

    // R7
    write_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid && cp_ready && cp_wr && rd_fld != '0) |=>
            (rf_we && done && rf_data == $past(cp_result)));

    // R10
    done_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cp_valid);
endmodule

// File: tb/sim_cop_dispatch.sv
module sim_cop_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [31:0] iss_insn = '0, iss_opa = '0, iss_opb = '0;
    logic        iss_ready, cp_valid;
    logic [31:0] cp_insn, cp_opa, cp_opb;
    logic        cp_ready = 1'b0, cp_wait = 1'b0, cp_wr = 1'b0;
    logic [31:0] cp_result = '0;
    logic        rf_we, done, exc_pulse;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cop_dispatch u0 (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_insn(iss_insn), .iss_opa(iss_opa), .iss_opb(iss_opb),
        .iss_ready(iss_ready), .cp_valid(cp_valid), .cp_insn(cp_insn),
        .cp_opa(cp_opa), .cp_opb(cp_opb),
        .cp_ready(cp_ready), .cp_wait(cp_wait), .cp_wr(cp_wr), .cp_result(cp_result),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
        .done(done), .exc_pulse(exc_pulse)
    );

    function automatic bit exp_we(input bit wr, input logic [31:0] insn);
        return wr && (insn[11:7] != 5'd0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // mode 0: ready at cycle d; mode 1: silence; mode 2: wait from cycle d for hold cycles, then ready
    task automatic do_op(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b,
                         input int mode, input int d, input int hold,
                         input bit wr, input logic [31:0] res);
        bit poke;
        int last;
        poke = (mode == 1) || (d >= 4);
        @(negedge clk);
        chk("R1 idle before issue", {31'd0, iss_ready}, 32'd1);
        iss_valid = 1'b1; iss_insn = insn; iss_opa = a; iss_opb = b;
        @(negedge clk);
        iss_valid = 1'b0;
        chk("R2 valid raised", {31'd0, cp_valid}, 32'd1);
        chk("R2 insn", cp_insn, insn);
        chk("R2 opa", cp_opa, a);
        chk("R2 opb", cp_opb, b);
        chk("R2 busy", {31'd0, iss_ready}, 32'd0);
        last = (mode == 1) ? 16 : ((mode == 0) ? d : d + hold);
        for (int k = 0; k < last; k++) begin
            if (k > 0) begin
                chk(mode == 2 ? "R6 still valid" : "R4 still valid", {31'd0, cp_valid}, 32'd1);
                chk(mode == 2 ? "R6 no exception" : "R4 no early exception", {31'd0, exc_pulse}, 32'd0);
            end
            if (poke && k == 2) begin
                iss_valid = 1'b1; iss_insn = ~insn; iss_opa = ~a; iss_opb = ~b;
            end
            if (poke && k == 3) begin
                iss_valid = 1'b0;
                chk("R3 insn held", cp_insn, insn);
                chk("R3 opa held", cp_opa, a);
                chk("R3 opb held", cp_opb, b);
            end
            if (mode == 2 && k >= d) cp_wait = 1'b1;
            @(negedge clk);
        end
        iss_valid = 1'b0;
        if (mode == 1) begin
            chk("R4 exception", {31'd0, exc_pulse}, 32'd1);
            chk("R4 valid dropped", {31'd0, cp_valid}, 32'd0);
            chk("R4 no done", {31'd0, done}, 32'd0);
            chk("R4 no write", {31'd0, rf_we}, 32'd0);
            @(negedge clk);
            chk("R4 single pulse", {31'd0, exc_pulse}, 32'd0);
        end else begin
            cp_ready = 1'b1; cp_wr = wr; cp_result = res;
            @(negedge clk);
            cp_ready = 1'b0; cp_wait = 1'b0; cp_wr = 1'b0; cp_result = ~res;
            chk("R10 done", {31'd0, done}, 32'd1);
            chk("R10 valid dropped", {31'd0, cp_valid}, 32'd0);
            chk(d == 15 ? "R5 no exception" : "R10 no exception", {31'd0, exc_pulse}, 32'd0);
            if (!wr) chk("R8 no write", {31'd0, rf_we}, 32'd0);
            else if (insn[11:7] == 5'd0) chk("R9 rd zero", {31'd0, rf_we}, 32'd0);
            else begin
                chk("R7 write enable", {31'd0, rf_we}, {31'd0, exp_we(wr, insn)});
                chk("R7 index", {27'd0, rf_idx}, {27'd0, insn[11:7]});
                chk("R7 data", rf_data, res);
            end
            @(negedge clk);
            chk("R10 done pulse", {31'd0, done}, 32'd0);
            chk("R7 write pulse", {31'd0, rf_we}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {31'd0, iss_ready}, 32'd1);
        chk("R1 valid", {31'd0, cp_valid}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 exc", {31'd0, exc_pulse}, 32'd0);
        chk("R1 we", {31'd0, rf_we}, 32'd0);
        // directed corner cases
        do_op(32'h0000_02B3, 32'd7, 32'd9, 0, 0, 0, 1'b1, 32'hDEAD_0001);    // R7 rd=5
        do_op(32'h0000_0033, 32'd1, 32'd2, 0, 2, 0, 1'b1, 32'h1111_2222);    // R9 rd=0
        do_op(32'h0000_0FB3, 32'd3, 32'd4, 0, 5, 0, 1'b0, 32'h3333_4444);    // R8
        do_op(32'h0000_0733, 32'd5, 32'd6, 0, 15, 0, 1'b1, 32'h5555_6666);   // R5
        do_op(32'h0000_0AB3, 32'd8, 32'd9, 1, 0, 0, 1'b0, 32'h0);           // R4
        do_op(32'h0000_0CB3, 32'd1, 32'd1, 2, 15, 100, 1'b1, 32'hCAFE_F00D); // R6
        do_op(32'h0000_04B3, 32'd2, 32'd2, 0, 10, 0, 1'b1, 32'h0BAD_BEEF);   // R11 partial count
        do_op(32'h0000_04B3, 32'd2, 32'd2, 1, 0, 0, 1'b0, 32'h0);           // R11 full window after it
        // constrained random
        for (int i = 0; i < 80; i++) begin
            int m;
            int dd;
            logic [31:0] ins;
            m   = $urandom % 3;
            dd  = $urandom % 16;
            ins = $urandom;
            if ($urandom % 5 == 0) ins[11:7] = 5'd0;
            do_op(ins, $urandom, $urandom, m, dd, 1 + ($urandom % 40),
                  1'($urandom % 2), $urandom);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule